// File: doc/BRIEF.md
# Microcode Control-Flow Watchdog Automaton

This block sits beside a microcoded processor and watches the full set of control enables that the sequencer drives on every micro-step. It runs its own deterministic automaton that mirrors the legal microcode sequence: three fetch steps, then an instruction path picked by the opcode (add, load, multiply or no-op), then back to the first fetch step. For each micro-step it computes the exact control word the current state must show and compares it with the observed one. Unused fields must be zero. Any difference, an unknown opcode, or an extra enable (for example, a hidden memory write of an ALU result) sends the automaton into an absorbing fault state. The predicate output then drops and a one-cycle halt request is raised.

A step is evaluated only when the valid strobe is high. The observed signals pass through a configurable 0 to 2 stage delay line, to allow for the transport latency between the watched die and the monitor. The fault state is left only through the clear input or reset. The control word that caused the fault is held for inspection.

Top module: `ctrl_flow_monitor`

## Requirements
- R1: The control word is 17 bits, most significant first: ir_ld[16], reg_sel[15:14], reg_wr[13], reg_en[12], a_ld[11], b_ld[10], alu_op[9:7], alu_en[6], ma_ld[5], mem_wr[4], mem_en[3], imm_sel[2:1], imm_en[0]. The reg_sel codes are rs=0, rt=1, rd=2, pc=3. The alu_op codes are none=0, add=1, inc4=2, mul=3.
- R2: After reset the state code is 0 (first fetch step), predicate_ok_o=1, fault_o=0, halt_req_o=0 and bad_vec_o=0.
- R3: Each state expects one exact control word, and every field not named below is 0. fetch0: pc select, reg_en, a_ld, ma_ld. fetch1: ir_ld, mem_en. fetch2: pc select, reg_wr, alu_op=inc4, alu_en. add0/mul0: rs select, reg_en, a_ld. add1/mul1: rt select, reg_en, b_ld. add2: rd select, reg_wr, alu_op=add, alu_en. mul2: the same as add2 with alu_op=mul. load0: rs select, reg_en, ma_ld. load1: rt select, reg_wr, mem_en. nop0: all zero. A step matches only if the word is bit-for-bit equal, so a single extra enable is a mismatch.
- R4: The state codes are fetch0=0, fetch1=1, fetch2=2, add0..2=3..5, load0..1=6..7, mul0..2=8..10, nop0=11, fault=15. Each matching step advances fetch0→fetch1→fetch2. In fetch2 the opcode selects the path (nop=0, add=1, load=2, mul=3). The last step of every path returns to fetch0.
- R5: A matching fetch2 step with any opcode other than 0 to 3 moves to fault.
- R6: A non-matching step moves to fault: fault_o=1 and predicate_ok_o=0. This includes the add2 word with ma_ld, mem_wr and mem_en also set.
- R7: On entry to fault, bad_vec_o takes the control word of the step that caused it, and halt_req_o is high for exactly one cycle.
- R8: The fault state ignores all steps and keeps bad_vec_o until clear_i or reset. clear_i has priority over a step in the same cycle. It returns the state to fetch0 and sets bad_vec_o to 0 after one edge.
- R9: A cycle with valid low changes nothing, whatever ctrl_i and opcode_i are.
- R10: A step presented at edge k shows at the outputs after edge k+LAT. With the default LAT=1, the outputs still reflect the old state one edge after the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Leaves the fault state, back to fetch0 |
| valid_i | input | 1 | The current micro-step is to be evaluated |
| opcode_i | input | OPC_W | Instruction register opcode |
| ctrl_i | input | 17 | Observed control word (R1 layout) |
| predicate_ok_o | output | 1 | High while no deviation has been seen |
| fault_o | output | 1 | Automaton is in the fault state |
| halt_req_o | output | 1 | One-cycle halt request on fault entry |
| exp_state_o | output | 4 | Current automaton state code |
| bad_vec_o | output | 17 | Control word that caused the fault |

## Verification
A wrong internal state is visible at exp_state_o on the cycle after the offending step has passed through the delay line. One step later it also shows at predicate_ok_o, because the next correct control word no longer matches the state the monitor expects. The table walk compares the state code after every micro-step of every instruction path, so a wrong successor or a wrong dispatch shows within one step. The directed tests cover the sticky fault, capture of the bad word, the single-cycle halt pulse, the latency, and the fact that stalled cycles are ignored.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int SEL_W  = 2;
  localparam int ALU_W  = 3;
  localparam int XSEL_W = 2;

  typedef struct packed {
    logic              ir_ld;
    logic [SEL_W-1:0]  reg_sel;
    logic              reg_wr;
    logic              reg_en;
    logic              a_ld;
    logic              b_ld;
    logic [ALU_W-1:0]  alu_op;
    logic              alu_en;
    logic              ma_ld;
    logic              mem_wr;
    logic              mem_en;
    logic [XSEL_W-1:0] imm_sel;
    logic              imm_en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [SEL_W-1:0] SEL_RS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_RT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RD = 2'd2;
  localparam logic [SEL_W-1:0] SEL_PC = 2'd3;

  localparam logic [ALU_W-1:0] ALU_NONE = 3'd0;
  localparam logic [ALU_W-1:0] ALU_ADD  = 3'd1;
  localparam logic [ALU_W-1:0] ALU_INC4 = 3'd2;
  localparam logic [ALU_W-1:0] ALU_MUL  = 3'd3;

  typedef enum logic [3:0] {
    ST_FETCH0 = 4'd0,
    ST_FETCH1 = 4'd1,
    ST_FETCH2 = 4'd2,
    ST_ADD0   = 4'd3,
    ST_ADD1   = 4'd4,
    ST_ADD2   = 4'd5,
    ST_LD0    = 4'd6,
    ST_LD1    = 4'd7,
    ST_MUL0   = 4'd8,
    ST_MUL1   = 4'd9,
    ST_MUL2   = 4'd10,
    ST_NOP0   = 4'd11,
    ST_FAULT  = 4'd15
  } st_e;
endpackage

// File: rtl/cfm_delay.sv
module cfm_delay #(
  parameter int W   = 8,
  parameter int LAT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (LAT == 0) begin : g_thru
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg_q [LAT];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < LAT; k++) stg_q[k] <= '0;
      end else begin
        stg_q[0] <= d_i;
        for (int k = 1; k < LAT; k++) stg_q[k] <= stg_q[k-1];
      end
    end
    assign q_o = stg_q[LAT-1];
  end
endmodule

// File: rtl/cfm_expect.sv
module cfm_expect
  import cfm_pkg::*;
(
  input  st_e  st_i,
  output ctl_t exp_o
);
  always_comb begin
    exp_o = '0;
    unique case (st_i)
      ST_FETCH0: begin
        exp_o.reg_sel = SEL_PC; exp_o.reg_en = 1'b1;
        exp_o.a_ld = 1'b1; exp_o.ma_ld = 1'b1;
      end
      ST_FETCH1: begin
        exp_o.ir_ld = 1'b1; exp_o.mem_en = 1'b1;
      end
      ST_FETCH2: begin
        exp_o.reg_sel = SEL_PC; exp_o.reg_wr = 1'b1;
        exp_o.alu_op = ALU_INC4; exp_o.alu_en = 1'b1;
      end
      ST_ADD0, ST_MUL0: begin
        exp_o.reg_sel = SEL_RS; exp_o.reg_en = 1'b1; exp_o.a_ld = 1'b1;
      end
      ST_ADD1, ST_MUL1: begin
        exp_o.reg_sel = SEL_RT; exp_o.reg_en = 1'b1; exp_o.b_ld = 1'b1;
      end
      ST_ADD2: begin
        exp_o.reg_sel = SEL_RD; exp_o.reg_wr = 1'b1;
        exp_o.alu_op = ALU_ADD; exp_o.alu_en = 1'b1;
      end
      ST_MUL2: begin
        exp_o.reg_sel = SEL_RD; exp_o.reg_wr = 1'b1;
        exp_o.alu_op = ALU_MUL; exp_o.alu_en = 1'b1;
      end
      ST_LD0: begin
        exp_o.reg_sel = SEL_RS; exp_o.reg_en = 1'b1; exp_o.ma_ld = 1'b1;
      end
      ST_LD1: begin
        exp_o.reg_sel = SEL_RT; exp_o.reg_wr = 1'b1; exp_o.mem_en = 1'b1;
      end
      default: exp_o = '0;
    endcase
  end
endmodule

// File: rtl/cfm_next.sv
module cfm_next
  import cfm_pkg::*;
#(
  parameter int                 OPC_W   = 6,
  parameter logic [OPC_W-1:0]   OP_NOP  = 'd0,
  parameter logic [OPC_W-1:0]   OP_ADD  = 'd1,
  parameter logic [OPC_W-1:0]   OP_LOAD = 'd2,
  parameter logic [OPC_W-1:0]   OP_MUL  = 'd3
) (
  input  st_e              st_i,
  input  logic [OPC_W-1:0] opc_i,
  output st_e              nxt_o
);
  always_comb begin
    unique case (st_i)
      ST_FETCH0: nxt_o = ST_FETCH1;
      ST_FETCH1: nxt_o = ST_FETCH2;
      ST_FETCH2: begin
        if      (opc_i == OP_ADD)  nxt_o = ST_ADD0;
        else if (opc_i == OP_LOAD) nxt_o = ST_LD0;
        else if (opc_i == OP_MUL)  nxt_o = ST_MUL0;
        else if (opc_i == OP_NOP)  nxt_o = ST_NOP0;
        else                       nxt_o = ST_FAULT;
      end
      ST_ADD0: nxt_o = ST_ADD1;
      ST_ADD1: nxt_o = ST_ADD2;
      ST_MUL0: nxt_o = ST_MUL1;
      ST_MUL1: nxt_o = ST_MUL2;
      ST_LD0:  nxt_o = ST_LD1;
      ST_ADD2, ST_MUL2, ST_LD1, ST_NOP0: nxt_o = ST_FETCH0;
      default: nxt_o = ST_FAULT;
    endcase
  end
endmodule

// File: rtl/ctrl_flow_monitor.sv
module ctrl_flow_monitor
  import cfm_pkg::*;
#(
  parameter int               OPC_W   = 6,
  parameter int               LAT     = 1,
  parameter logic [OPC_W-1:0] OP_NOP  = 'd0,
  parameter logic [OPC_W-1:0] OP_ADD  = 'd1,
  parameter logic [OPC_W-1:0] OP_LOAD = 'd2,
  parameter logic [OPC_W-1:0] OP_MUL  = 'd3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [CTL_W-1:0] ctrl_i,
  output logic             predicate_ok_o,
  output logic             fault_o,
  output logic             halt_req_o,
  output logic [3:0]       exp_state_o,
  output logic [CTL_W-1:0] bad_vec_o
);
  localparam int PW = 1 + OPC_W + CTL_W;

  logic [PW-1:0]    pipe_q;
  logic             pipe_v;
  logic [OPC_W-1:0] pipe_opc;
  logic [CTL_W-1:0] pipe_vec;
  st_e              st_q, st_d, st_nxt;
  ctl_t             exp_vec;
  logic [CTL_W-1:0] bad_q;
  logic             halt_q;
  logic             entering;

  cfm_delay #(.W(PW), .LAT(LAT)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({valid_i, opcode_i, ctrl_i}),
    .q_o   (pipe_q)
  );
  assign {pipe_v, pipe_opc, pipe_vec} = pipe_q;

  cfm_expect u_expect (.st_i(st_q), .exp_o(exp_vec));

  cfm_next #(
    .OPC_W(OPC_W), .OP_NOP(OP_NOP), .OP_ADD(OP_ADD),
    .OP_LOAD(OP_LOAD), .OP_MUL(OP_MUL)
  ) u_next (.st_i(st_q), .opc_i(pipe_opc), .nxt_o(st_nxt));

  always_comb begin
    st_d = st_q;
    if (clear_i)                   st_d = ST_FETCH0;
    else if (st_q == ST_FAULT)     st_d = ST_FAULT;
    else if (pipe_v) begin
      if (pipe_vec == exp_vec)     st_d = st_nxt;
      else                         st_d = ST_FAULT;
    end
  end

  assign entering = (st_d == ST_FAULT) && (st_q != ST_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FETCH0;
      bad_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      halt_q <= entering;
      if (clear_i)       bad_q <= '0;
      else if (entering) bad_q <= pipe_vec;
    end
  end

  assign fault_o        = (st_q == ST_FAULT);
  assign predicate_ok_o = !fault_o;
  assign halt_req_o     = halt_q;
  assign exp_state_o    = st_q;
  assign bad_vec_o      = bad_q;
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int CTL_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             step_v_i,
  input logic             fault_i,
  input logic             halt_i,
  input logic [3:0]       state_i,
  input logic [CTL_W-1:0] bad_vec_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_vals_r2: assert (state_i == 4'd0 && !fault_i && !halt_i && bad_vec_i == '0)
        else $error("reset values wrong");
    end
  end

  p_state_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i <= 4'd11) || (state_i == 4'd15))
    else $error("illegal state code");

  p_halt_on_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_i) |-> halt_i)
    else $error("no halt on fault entry");

  p_halt_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !halt_i)
    else $error("halt longer than one cycle");

  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !clear_i |=> fault_i)
    else $error("fault left without clear");

  p_bad_vec_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !clear_i |=> $stable(bad_vec_i))
    else $error("bad vector changed in fault");

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_i == 4'd0) && !fault_i && (bad_vec_i == '0))
    else $error("clear did not restore fetch0");

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_v_i && !clear_i |=> $stable(state_i))
    else $error("state moved without a step");
endmodule

bind ctrl_flow_monitor cfm_checker #(.CTL_W(cfm_pkg::CTL_W)) u_cfm_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .step_v_i (pipe_v),
  .fault_i  (fault_o),
  .halt_i   (halt_req_o),
  .state_i  (exp_state_o),
  .bad_vec_i(bad_vec_o)
);

// File: tb/ctrl_flow_monitor_bench.sv
module ctrl_flow_monitor_bench;
  localparam int LAT = 1;

  function automatic logic [16:0] mk(int ir, int sel, int wr, int en, int a, int b,
                                     int op, int ae, int ma, int mw, int me, int xs, int xe);
    logic [16:0] v;
    v = {ir[0], sel[1:0], wr[0], en[0], a[0], b[0], op[2:0], ae[0],
         ma[0], mw[0], me[0], xs[1:0], xe[0]};
    return v;
  endfunction

  // R1 field layout, R3 expected words
  localparam logic [16:0] F0V = mk(0,3,0,1,1,0,0,0,1,0,0,0,0);
  localparam logic [16:0] F1V = mk(1,0,0,0,0,0,0,0,0,0,1,0,0);
  localparam logic [16:0] F2V = mk(0,3,1,0,0,0,2,1,0,0,0,0,0);
  localparam logic [16:0] A0V = mk(0,0,0,1,1,0,0,0,0,0,0,0,0);
  localparam logic [16:0] A1V = mk(0,1,0,1,0,1,0,0,0,0,0,0,0);
  localparam logic [16:0] A2V = mk(0,2,1,0,0,0,1,1,0,0,0,0,0);
  localparam logic [16:0] M2V = mk(0,2,1,0,0,0,3,1,0,0,0,0,0);
  localparam logic [16:0] L0V = mk(0,0,0,1,0,0,0,0,1,0,0,0,0);
  localparam logic [16:0] L1V = mk(0,1,1,0,0,0,0,0,0,0,1,0,0);
  localparam logic [16:0] LEAK = mk(0,2,1,0,0,0,1,1,1,1,1,0,0);

  typedef struct packed {
    logic [16:0] vec;
    logic [5:0]  opc;
    logic [3:0]  st;
  } row_t;

  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{F0V, 6'd0, 4'd1}, '{F1V, 6'd0, 4'd2}, '{F2V, 6'd1, 4'd3},
    '{A0V, 6'd0, 4'd4}, '{A1V, 6'd0, 4'd5}, '{A2V, 6'd0, 4'd0},
    '{F0V, 6'd0, 4'd1}, '{F1V, 6'd0, 4'd2}, '{F2V, 6'd0, 4'd11},
    '{17'd0, 6'd0, 4'd0},
    '{F0V, 6'd0, 4'd1}, '{F1V, 6'd0, 4'd2}, '{F2V, 6'd2, 4'd6},
    '{L0V, 6'd0, 4'd7}, '{L1V, 6'd0, 4'd0},
    '{F0V, 6'd0, 4'd1}, '{F1V, 6'd0, 4'd2}, '{F2V, 6'd3, 4'd8},
    '{A0V, 6'd0, 4'd9}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [16:0] ctrl_i = '0;
  logic        predicate_ok_o, fault_o, halt_req_o;
  logic [3:0]  exp_state_o;
  logic [16:0] bad_vec_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  ctrl_flow_monitor #(.OPC_W(6), .LAT(LAT)) u_ctrl_flow_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
    .opcode_i(opcode_i), .ctrl_i(ctrl_i), .predicate_ok_o(predicate_ok_o),
    .fault_o(fault_o), .halt_req_o(halt_req_o), .exp_state_o(exp_state_o),
    .bad_vec_o(bad_vec_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // present one valid step, return one negedge later with valid low
  task automatic step(logic [16:0] vec, logic [5:0] opc);
    valid_i = 1'b1; ctrl_i = vec; opcode_i = opc;
    @(negedge clk_i);
    valid_i = 1'b0; ctrl_i = '0; opcode_i = '0;
  endtask

  task automatic settle();
    repeat (LAT) @(negedge clk_i);
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R2 reset state
    chk("R2 state", exp_state_o, 0);
    chk("R2 ok", predicate_ok_o, 1);
    chk("R2 halt", halt_req_o, 0);
    chk("R2 bad_vec", bad_vec_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 table walk over every instruction path
    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].vec, TBL[i].opc);
      settle();
      chk($sformatf("R4 row %0d state", i), exp_state_o, TBL[i].st);
      chk($sformatf("R3 row %0d ok", i), predicate_ok_o, 1);
    end
    step(A1V, 6'd0); settle();
    chk("R4 mul1", exp_state_o, 10);
    step(M2V, 6'd0); settle();
    chk("R4 mul2 returns", exp_state_o, 0);

    // R9 stalled cycles with garbage ignored
    ctrl_i = 17'h1FFFF; opcode_i = 6'h3F;
    repeat (4) @(negedge clk_i);
    ctrl_i = '0; opcode_i = '0;
    settle();
    chk("R9 stall state", exp_state_o, 0);
    chk("R9 stall ok", predicate_ok_o, 1);

    // R6 leak pattern, R10 latency, R7 capture and halt pulse
    step(F0V, 0); step(F1V, 0); step(F2V, 6'd1); step(A0V, 0); step(A1V, 0);
    settle();
    chk("R4 add1 before leak", exp_state_o, 5);
    step(LEAK, 0);
    chk("R10 ok still high one edge after step", predicate_ok_o, 1);
    @(negedge clk_i);
    chk("R6 leak fault", fault_o, 1);
    chk("R6 leak ok low", predicate_ok_o, 0);
    chk("R6 leak state", exp_state_o, 15);
    chk("R7 halt high", halt_req_o, 1);
    chk("R7 R1 bad_vec leak", bad_vec_o, LEAK);
    @(negedge clk_i);
    chk("R7 halt one cycle", halt_req_o, 0);

    // R8 sticky: good steps ignored, bad_vec held
    step(F0V, 0); step(F1V, 0); step(17'h00123, 0);
    settle();
    chk("R8 still fault", fault_o, 1);
    chk("R8 bad_vec held", bad_vec_o, LEAK);
    chk("R8 no new halt", halt_req_o, 0);
    // R8 clear has priority over a simultaneous bad step
    clear_i = 1'b1; valid_i = 1'b1; ctrl_i = 17'h1FFFF;
    @(negedge clk_i);
    clear_i = 1'b0; valid_i = 1'b0; ctrl_i = '0;
    chk("R8 clear state", exp_state_o, 0);
    chk("R8 clear ok", predicate_ok_o, 1);
    chk("R8 clear bad_vec", bad_vec_o, 0);
    settle();
    // the delayed step arrives after clear and is evaluated against fetch0
    @(negedge clk_i);
    chk("R8 R10 delayed step after clear", exp_state_o, 15);
    do_clear();
    settle();
    chk("R8 clear again", exp_state_o, 0);

    // R5 unknown opcode at dispatch
    step(F0V, 0); step(F1V, 0); step(F2V, 6'h2A);
    settle();
    chk("R5 unknown opcode fault", fault_o, 1);
    chk("R5 bad_vec is fetch2 word", bad_vec_o, F2V);
    do_clear();
    settle();

    // R3 one stray unused enable (imm_en) in fetch0
    step(F0V | 17'h00001, 0);
    settle();
    chk("R3 stray imm_en faults", fault_o, 1);
    chk("R3 stray bad_vec", bad_vec_o, F0V | 17'h00001);

    // R2 asynchronous reset leaves fault
    #1 rst_ni = 1'b0;
    #1;
    chk("R2 async reset state", exp_state_o, 0);
    chk("R2 async reset bad_vec", bad_vec_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 ok after reset", predicate_ok_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule